// File: doc/BRIEF.md
# Video Word Channel Encoder

This block turns a stream of 32-bit pixel words into three 10-bit channel symbols per word for a DVI-style serial link. A control bit carried inside each word chooses how that word is treated. With the bit set, the word already holds three ready-made 10-bit symbols, which pass straight through. With it clear, the three upper bytes are colour components. Each one is coded into a 10-bit symbol by transition minimisation and then DC balancing against its channel's own running disparity.

Palette-driven sources present their table entries as they are. A palette entry can therefore emit raw symbols on purpose or by accident. Direct 24-bit colour sources assert `direct_mode`, which zeroes the low byte of the word, so such a word can never take the raw path. While `blank` is high, each channel sends one of four fixed control symbols, selected by its own pair of control bits, and its disparity returns to zero. The serialisers and the link clocking sit outside this block.

Top module: `vwe_encoder`

## Requirements
- R1: When a word is accepted with `direct_mode` low, `blank` low and word bit 1 set, the outputs are raw symbols: `sym2` = word[31:22], `sym1` = word[21:12], `sym0` = word[11:2].
- R2: When a word is accepted with `blank` low and bit 1 clear after masking, each channel carries the coded form of one byte: `sym0` codes word[15:8], `sym1` codes word[23:16], `sym2` codes word[31:24].
- R3: While `direct_mode` is high, word[7:0] is replaced by zero before any decision, so the word is always colour coded, even if word bit 1 was set.
- R4: The first coding step gives a 9-bit value q. q[0] equals d[0]. Each following q[i] is q[i-1] XNOR d[i] when d has more than four ones, or exactly four ones and d[0]=0. Otherwise it is q[i-1] XOR d[i]. q[8] is 1 for the XOR form and 0 for the XNOR form.
- R5: Let b be the ones minus the zeros in q[7:0], and c the channel's disparity. If c=0 or b=0: out = {~q8, q8, q8 ? q[7:0] : ~q[7:0]}, and c moves by +b when q8 is 1, by -b when q8 is 0. Else, if c and b have the same sign: out = {1, q8, ~q[7:0]}, and c moves by 2*q8 - b. Otherwise: out = {0, q8, q[7:0]}, and c moves by b - 2*(1-q8). Each channel keeps its own c.
- R6: An accepted word with `blank` high emits control symbols on every channel. `ctl[1:0]` drives channel 0, `ctl[3:2]` drives channel 1 and `ctl[5:4]` drives channel 2. The codes are 00 -> 10'b1101010100, 01 -> 10'b0010101011, 10 -> 10'b0101010100 and 11 -> 10'b1010101011.
- R7: A blanking word resets all three disparities to zero.
- R8: `out_valid` follows `in_valid` exactly two clock cycles later, and both paths have that same latency.
- R9: A raw word leaves every channel's disparity unchanged.
- R10: Cycles with `in_valid` low change neither the symbols nor the disparities, and `out_valid` is low two cycles later.
- R11: While `rst` is high, `out_valid` is 0, every symbol is zero and every disparity is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A word is presented this cycle |
| in_word | input | 32 | Pixel word; bit 1 selects raw symbols |
| direct_mode | input | 1 | Direct 24-bit colour source: low byte masked |
| blank | input | 1 | Blanking period: send control symbols |
| ctl | input | 6 | Two control bits per channel |
| out_valid | output | 1 | Symbols below are new this cycle |
| sym0 | output | 10 | Channel 0 symbol |
| sym1 | output | 10 | Channel 1 symbol |
| sym2 | output | 10 | Channel 2 symbol |

## Verification
On every cycle, the assertions check four things: the two-cycle valid latency, raw pass-through, the control symbol for each blanking code, and the zeroed disparity after blanking. They also check that raw words and idle cycles leave the disparity untouched, and that it stays even. Only the bench scenarios can show that the coded symbols are correct. They run long colour sequences that swing the disparity both ways, and they mask direct words whose low byte has bit 1 set. They also show how a raw word or an idle gap between colour words carries the disparity into the next coded word.

// File: rtl/vwe_pkg.sv
package vwe_pkg;
  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int SYM_W   = 10;
  localparam int QM_W    = BYTE_W + 1;
  localparam int NCH     = 3;
  localparam int SEL_BIT = 1;
  localparam int LIT_LSB = SEL_BIT + 1;

  localparam logic [SYM_W-1:0] CTL_SYM0 = 10'b1101010100;
  localparam logic [SYM_W-1:0] CTL_SYM1 = 10'b0010101011;
  localparam logic [SYM_W-1:0] CTL_SYM2 = 10'b0101010100;
  localparam logic [SYM_W-1:0] CTL_SYM3 = 10'b1010101011;

  function automatic logic [SYM_W-1:0] ctl_symbol(input logic [1:0] c);
    case (c)
      2'b00:   return CTL_SYM0;
      2'b01:   return CTL_SYM1;
      2'b10:   return CTL_SYM2;
      default: return CTL_SYM3;
    endcase
  endfunction
endpackage

// File: rtl/vwe_tmin.sv
module vwe_tmin
  import vwe_pkg::*;
(
  input  logic [BYTE_W-1:0] d,
  output logic [QM_W-1:0]   qm
);
  localparam int HALF = BYTE_W / 2;

  logic [$clog2(BYTE_W+1)-1:0] ones;
  logic                        use_xnor;
  logic [BYTE_W-1:0]           chain;

  always_comb begin
    ones = '0;
    for (int i = 0; i < BYTE_W; i++) ones = ones + ($clog2(BYTE_W+1))'(d[i]);
  end

  assign use_xnor = (ones > HALF) || ((ones == HALF) && !d[0]);

  always_comb begin
    chain[0] = d[0];
    for (int i = 1; i < BYTE_W; i++)
      chain[i] = use_xnor ? ~(chain[i-1] ^ d[i]) : (chain[i-1] ^ d[i]);
  end

  assign qm = {~use_xnor, chain};
endmodule

// File: rtl/vwe_front.sv
module vwe_front
  import vwe_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            in_valid,
  input  logic [WORD_W-1:0]               in_word,
  input  logic                            direct_mode,
  input  logic                            blank,
  input  logic [2*NCH-1:0]                ctl,
  output logic                            s1_valid,
  output logic                            s1_blank,
  output logic                            s1_lit,
  output logic [2*NCH-1:0]                s1_ctl,
  output logic [NCH-1:0][SYM_W-1:0]       s1_raw,
  output logic [NCH-1:0][QM_W-1:0]        s1_qm
);
  logic [WORD_W-1:0]         eff;
  logic [NCH-1:0][QM_W-1:0]  qm_c;
  logic                      unused_bit0;

  // Direct colour words lose their low byte, so the select bit reads 0.
  assign eff         = direct_mode ? {in_word[WORD_W-1:BYTE_W], {BYTE_W{1'b0}}} : in_word;
  assign unused_bit0 = eff[0];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    vwe_tmin u_tmin (
      .d  (eff[BYTE_W*(ch+1) +: BYTE_W]),
      .qm (qm_c[ch])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        s1_raw[ch] <= '0;
        s1_qm[ch]  <= '0;
      end else if (in_valid) begin
        s1_raw[ch] <= eff[LIT_LSB + SYM_W*ch +: SYM_W];
        s1_qm[ch]  <= qm_c[ch];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_blank <= 1'b0;
      s1_lit   <= 1'b0;
      s1_ctl   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_blank <= blank;
        s1_lit   <= eff[SEL_BIT];
        s1_ctl   <= ctl;
      end
    end
  end
endmodule

// File: rtl/vwe_dcbal.sv
module vwe_dcbal
  import vwe_pkg::*;
#(
  parameter int DISP_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     blank,
  input  logic                     lit,
  input  logic [1:0]               ctl,
  input  logic [SYM_W-1:0]         raw,
  input  logic [QM_W-1:0]          qm,
  output logic [SYM_W-1:0]         sym_o,
  output logic signed [DISP_W-1:0] disp_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic signed [DISP_W-1:0] TWO  = DISP_W'(2);
  localparam logic signed [DISP_W-1:0] FULL = DISP_W'(BYTE_W);

  logic [CNT_W-1:0]          ones;
  logic signed [DISP_W-1:0]  ones_s, bal, two_q, two_nq, disp_n;
  logic [SYM_W-1:0]          enc;
  logic                      q8;
  logic [BYTE_W-1:0]         qd;

  assign q8 = qm[BYTE_W];
  assign qd = qm[BYTE_W-1:0];

  always_comb begin
    ones = '0;
    for (int i = 0; i < BYTE_W; i++) ones = ones + CNT_W'(qd[i]);
  end

  assign ones_s = DISP_W'(ones);
  assign bal    = (ones_s <<< 1) - FULL;
  assign two_q  = q8 ? TWO : '0;
  assign two_nq = q8 ? '0 : TWO;

  always_comb begin
    if ((disp_o == '0) || (bal == '0)) begin
      enc    = {~q8, q8, (q8 ? qd : ~qd)};
      disp_n = q8 ? (disp_o + bal) : (disp_o - bal);
    end else if (((disp_o > 0) && (bal > 0)) || ((disp_o < 0) && (bal < 0))) begin
      enc    = {1'b1, q8, ~qd};
      disp_n = disp_o + two_q - bal;
    end else begin
      enc    = {1'b0, q8, qd};
      disp_n = disp_o - two_nq + bal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_o  <= '0;
      disp_o <= '0;
    end else if (en) begin
      if (blank) begin
        sym_o  <= ctl_symbol(ctl);
        disp_o <= '0;
      end else if (lit) begin
        sym_o  <= raw;
      end else begin
        sym_o  <= enc;
        disp_o <= disp_n;
      end
    end
  end
endmodule

// File: rtl/vwe_encoder.sv
module vwe_encoder
  import vwe_pkg::*;
#(
  parameter int DISP_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       in_word,
  input  logic              direct_mode,
  input  logic              blank,
  input  logic [5:0]        ctl,
  output logic              out_valid,
  output logic [9:0]        sym0,
  output logic [9:0]        sym1,
  output logic [9:0]        sym2
);
  logic                        s1_valid, s1_blank, s1_lit;
  logic [2*NCH-1:0]            s1_ctl;
  logic [NCH-1:0][SYM_W-1:0]   s1_raw;
  logic [NCH-1:0][QM_W-1:0]    s1_qm;
  logic [NCH-1:0][SYM_W-1:0]   sym_arr;
  logic [NCH*DISP_W-1:0]       disp_flat;

  vwe_front u_front (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_word     (in_word),
    .direct_mode (direct_mode),
    .blank       (blank),
    .ctl         (ctl),
    .s1_valid    (s1_valid),
    .s1_blank    (s1_blank),
    .s1_lit      (s1_lit),
    .s1_ctl      (s1_ctl),
    .s1_raw      (s1_raw),
    .s1_qm       (s1_qm)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    logic signed [DISP_W-1:0] disp_ch;

    vwe_dcbal #(.DISP_W(DISP_W)) u_dcbal (
      .clk    (clk),
      .rst    (rst),
      .en     (s1_valid),
      .blank  (s1_blank),
      .lit    (s1_lit),
      .ctl    (s1_ctl[2*ch +: 2]),
      .raw    (s1_raw[ch]),
      .qm     (s1_qm[ch]),
      .sym_o  (sym_arr[ch]),
      .disp_o (disp_ch)
    );

    assign disp_flat[DISP_W*ch +: DISP_W] = disp_ch;
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= s1_valid;
  end

  assign sym0 = sym_arr[0];
  assign sym1 = sym_arr[1];
  assign sym2 = sym_arr[2];
endmodule

// File: rtl/vwe_checker.sv
module vwe_checker
  import vwe_pkg::*;
#(
  parameter int DISP_W = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [31:0]           in_word,
  input logic                  direct_mode,
  input logic                  blank,
  input logic [5:0]            ctl,
  input logic                  out_valid,
  input logic [9:0]            sym0,
  input logic [9:0]            sym1,
  input logic [9:0]            sym2,
  input logic [NCH*DISP_W-1:0] disp_flat
);
  logic [1:0] age;
  logic       ripe;
  logic       lit_in;

  always_ff @(posedge clk) begin
    if (rst)            age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assign ripe   = (age >= 2'd2);
  assign lit_in = in_valid && !blank && !direct_mode && in_word[1];

  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    ripe |-> (out_valid == $past(in_valid, 2)));

  assert_raw_pass_R1: assert property (@(posedge clk) disable iff (rst)
    (ripe && $past(lit_in, 2)) |-> ({sym2, sym1, sym0} == $past(in_word[31:2], 2)));

  assert_ctl_code_R6: assert property (@(posedge clk) disable iff (rst)
    (ripe && $past(in_valid && blank, 2)) |->
      (sym0 == ctl_symbol($past(ctl[1:0], 2)) &&
       sym1 == ctl_symbol($past(ctl[3:2], 2)) &&
       sym2 == ctl_symbol($past(ctl[5:4], 2))));

  assert_blank_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (ripe && $past(in_valid && blank, 2)) |-> (disp_flat == '0));

  assert_raw_keeps_disp_R9: assert property (@(posedge clk) disable iff (rst)
    (ripe && $past(lit_in, 2)) |-> $stable(disp_flat));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (ripe && !$past(in_valid, 2)) |-> ($stable({sym2, sym1, sym0}) && $stable(disp_flat)));

  // R5: every update moves the disparity by an even amount from zero
  assert_disp_even_R5: assert property (@(posedge clk) disable iff (rst)
    ripe |-> (!disp_flat[0] && !disp_flat[DISP_W] && !disp_flat[2*DISP_W]));
endmodule

bind vwe_encoder vwe_checker #(.DISP_W(DISP_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_word     (in_word),
  .direct_mode (direct_mode),
  .blank       (blank),
  .ctl         (ctl),
  .out_valid   (out_valid),
  .sym0        (sym0),
  .sym1        (sym1),
  .sym2        (sym2),
  .disp_flat   (disp_flat)
);

// File: tb/sim_vwe_encoder.sv
`timescale 1ns/1ps
module sim_vwe_encoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        direct_mode = 1'b0;
  logic        blank = 1'b0;
  logic [5:0]  ctl = '0;
  logic        out_valid;
  logic [9:0]  sym0, sym1, sym2;

  int n_cmp = 0;
  int n_bad = 0;
  bit reported = 1'b0;
  int ref_c [3] = '{0, 0, 0};
  logic [29:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  vwe_encoder u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .direct_mode(direct_mode), .blank(blank), .ctl(ctl),
    .out_valid(out_valid), .sym0(sym0), .sym1(sym1), .sym2(sym2)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] ctl_ref(input logic [1:0] c);
    logic [9:0] t [4] = '{10'b1101010100, 10'b0010101011, 10'b0101010100, 10'b1010101011};
    return t[c];
  endfunction

  function automatic logic [9:0] ref_code(input logic [7:0] d, inout int c);
    int n1 = 0;
    int ones = 0;
    int zeros;
    logic inv;
    logic [8:0] q;
    logic [9:0] r;
    for (int i = 0; i < 8; i++) n1 += int'(d[i]);
    inv = (n1 > 4) || (n1 == 4 && d[0] == 1'b0);
    q[0] = d[0];
    for (int i = 1; i < 8; i++) q[i] = inv ? (q[i-1] ~^ d[i]) : (q[i-1] ^ d[i]);
    q[8] = !inv;
    for (int i = 0; i < 8; i++) ones += int'(q[i]);
    zeros = 8 - ones;
    if (c == 0 || ones == zeros) begin
      r = {~q[8], q[8], (q[8] ? q[7:0] : ~q[7:0])};
      c += q[8] ? (ones - zeros) : (zeros - ones);
    end else if ((c > 0 && ones > zeros) || (c < 0 && zeros > ones)) begin
      r = {1'b1, q[8], ~q[7:0]};
      c += 2 * int'(q[8]) + zeros - ones;
    end else begin
      r = {1'b0, q[8], q[7:0]};
      c += -2 * int'(!q[8]) + ones - zeros;
    end
    return r;
  endfunction

  // Drive one accepted word and queue its expected symbols {sym2,sym1,sym0}.
  task automatic push(input logic [31:0] w, input bit dm, input bit bl, input logic [5:0] c, input string tag);
    logic [31:0] e;
    logic [29:0] x;
    @(negedge clk);
    in_valid = 1'b1; in_word = w; direct_mode = dm; blank = bl; ctl = c;
    e = dm ? {w[31:8], 8'h00} : w;
    if (bl) begin
      x = {ctl_ref(c[5:4]), ctl_ref(c[3:2]), ctl_ref(c[1:0])};
      for (int k = 0; k < 3; k++) ref_c[k] = 0;
    end else if (e[1]) begin
      x = e[31:2];
    end else begin
      x[9:0]   = ref_code(e[15:8],  ref_c[0]);
      x[19:10] = ref_code(e[23:16], ref_c[1]);
      x[29:20] = ref_code(e[31:24], ref_c[2]);
    end
    exp_q.push_back(x);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_word = 32'hDEAD_BEEF;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected out_valid", 32'(out_valid), 32'd0);
      end else begin
        logic [29:0] x;
        string t;
        x = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({sym2, sym1, sym0} == x, t, 32'({sym2, sym1, sym0}), 32'(x));
      end
    end
  end

  task automatic t_reset;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 out_valid in reset", 32'(out_valid), 32'd0);
    chk({sym2, sym1, sym0} == '0, "R11 symbols in reset", 32'({sym2, sym1, sym0}), 32'd0);
  endtask

  task automatic t_literal;
    push(32'hFFFF_FFFF, 1'b0, 1'b0, 6'h00, "R1 raw all ones");
    push(32'h5A5A_A5A6, 1'b0, 1'b0, 6'h00, "R1 raw pattern");
    push(32'h0000_0002, 1'b0, 1'b0, 6'h00, "R1 raw minimal");
    push(32'hC3F0_0F3E, 1'b0, 1'b0, 6'h00, "R1 palette entry with bit1");
    idle(3);
  endtask

  task automatic t_color;
    push(32'h0000_0000, 1'b0, 1'b0, 6'h00, "R2 R4 zero bytes");
    push(32'hFFFF_FF01, 1'b0, 1'b0, 6'h00, "R2 R4 full bytes");
    push(32'h1055_AA00, 1'b0, 1'b0, 6'h00, "R2 R5 mixed bytes");
    for (int k = 0; k < 24; k++)
      push({8'(k * 37 + 3), 8'(k * 91 + 17), 8'(k * 13 + 200), 8'(k * 4) & 8'hFC},
           1'b0, 1'b0, 6'h00, "R5 disparity sweep");
    for (int k = 0; k < 6; k++)
      push(32'h0101_0100, 1'b0, 1'b0, 6'h00, "R5 same-sign run");
    idle(3);
  endtask

  task automatic t_direct;
    push(32'h1234_56FF, 1'b1, 1'b0, 6'h00, "R3 direct low byte masked");
    push(32'hABCD_EF02, 1'b1, 1'b0, 6'h00, "R3 direct bit1 ignored");
    push(32'hABCD_EF02, 1'b0, 1'b0, 6'h00, "R1 same word not direct");
    idle(3);
  endtask

  task automatic t_blank;
    push(32'h77FF_1100, 1'b0, 1'b0, 6'h00, "R5 before blank");
    push(32'h0000_0000, 1'b0, 1'b1, 6'b11_10_01, "R6 ctl 3/2/1");
    push(32'hFFFF_FFFF, 1'b0, 1'b1, 6'b00_11_10, "R6 ctl 0/3/2");
    push(32'h1234_5678, 1'b0, 1'b1, 6'b01_00_00, "R6 ctl 1/0/0");
    push(32'h33CC_0F00, 1'b0, 1'b0, 6'h00, "R7 first word after blank");
    push(32'h33CC_0F00, 1'b0, 1'b0, 6'h00, "R7 second word after blank");
    idle(3);
  endtask

  task automatic t_raw_disp;
    push(32'hF0F1_0300, 1'b0, 1'b0, 6'h00, "R5 build disparity");
    push(32'h0E0F_0700, 1'b0, 1'b0, 6'h00, "R5 build disparity");
    push(32'h0000_0006, 1'b0, 1'b0, 6'h00, "R9 raw between colour");
    push(32'hFF80_3F00, 1'b0, 1'b0, 6'h00, "R9 colour after raw");
    idle(3);
  endtask

  task automatic t_latency;
    idle(2);
    push(32'h4455_6600, 1'b0, 1'b0, 6'h00, "R8 single word");
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R8 not yet after one cycle", 32'(out_valid), 32'd0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R8 valid after two cycles", 32'(out_valid), 32'd1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 single pulse", 32'(out_valid), 32'd0);
    push(32'h0000_3FFE, 1'b0, 1'b0, 6'h00, "R8 raw word");
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b1, "R8 raw path same latency", 32'(out_valid), 32'd1);
    idle(3);
  endtask

  task automatic t_idle;
    logic [29:0] held;
    push(32'hE1D2_C300, 1'b0, 1'b0, 6'h00, "R10 word before gap");
    idle(2);
    held = {sym2, sym1, sym0};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_word = 32'h0F0F_0F02;
      blank = 1'b1;
      chk({sym2, sym1, sym0} == held, "R10 symbols held while idle", 32'({sym2, sym1, sym0}), 32'(held));
      chk(out_valid == 1'b0, "R10 no valid while idle", 32'(out_valid), 32'd0);
    end
    push(32'hE1D2_C300, 1'b0, 1'b0, 6'h00, "R10 disparity kept over gap");
    idle(3);
  endtask

  task automatic report;
    if (!reported) begin
      reported = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_literal();
    t_color();
    t_direct();
    t_blank();
    t_raw_disp();
    t_latency();
    t_idle();
    idle(4);
    chk(exp_q.size() == 0, "R8 all words delivered", 32'(exp_q.size()), 32'd0);
    report();
    $finish;
  end
endmodule